// File: doc/BRIEF.md
# General-Purpose Timer with Compare, Capture and Output Pin

This block is a 32-bit up-counter that serves as an interval timer, an event timestamper and a waveform source at the same time. Software programs it through a one-cycle register write port and a combinational read port. A control word starts and stops counting. It also chooses an optional power-of-two prescaler and selects reload-on-wrap or one-shot behaviour. It enables comparison against a match value, and it configures the capture input and the timer output pin.

A capture pin is synchronised inside the block. A selected edge on it copies the current count into a capture register. The output pin can stay at a programmed idle level, emit a one-cycle inverted pulse per event, or flip on each event. Its events are wrap-around alone, or wrap-around and match. Three sticky status flags (match, wrap, capture) are cleared by writing ones. Each flag can be enabled onto the single interrupt line.

Register offsets (byte addresses on `reg_addr`): control 0x00, count 0x04, reload value 0x08, reload strobe 0x0C, match value 0x10, captured value 0x14, status flags 0x18, interrupt enables 0x1C. Status and enable bits: 0 match, 1 wrap, 2 capture.

Top module: `gpt_core`

## Requirements
- R1: After reset every register reads 0, `timer_out` is 0 and `irq` is 0.
- R2: With control bit 0 set and the prescaler off, the count rises by one on every clock. Once bit 0 is cleared, the count holds from the cycle after that write.
- R3: Control bit 5 enables the prescaler and bits 4:2 hold a ratio r from 0 to 7. The count then advances once every 2^(r+1) clocks.
- R4: With control bit 1 set, a step from 0xFFFFFFFF loads the count from the reload value and sets status bit 1.
- R5: With control bit 1 clear, a step from 0xFFFFFFFF gives count 0, sets status bit 1 and clears control bit 0, so counting stops.
- R6: A write of any data to the reload strobe offset loads the count from the reload value on the next clock.
- R7: With control bit 6 set, status bit 0 is set on the clock where the count steps onto the match value. With bit 6 clear, no match flag is raised.
- R8: The capture pin passes through a two-flop synchroniser. Control bits 9:8 select the edge: 00 none, 01 rising, 10 falling, 11 both. On a selected edge the count is copied to the captured value and status bit 2 is set. With control bit 13 set, a new edge is ignored while status bit 2 is still pending.
- R9: Control bit 7 is the idle level of `timer_out`, and bits 11:10 choose its events: 00 none, 01 wrap, 10 wrap or match. In pulse mode (bit 12 clear) the pin is inverted for one cycle after each event. In toggle mode (bit 12 set) it flips per event. Bit 14 forces the pin to the idle level.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it. A flag event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| cap_pin | input | 1 | Asynchronous capture event input |
| timer_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the counter on every cycle. They check that it holds while stopped, steps by one unprescaled, reloads or stops at wrap-around, and follows the reload strobe. They also check write-one-to-clear of the wrap flag, the forced idle level of the pin and a quiet interrupt line. The prescaler ratios, the cycle on which a match flag and an output pulse or toggle appear, and the synchroniser delay of the capture path are shown only by the bench's scenarios. The same holds for the edge selection and hold-while-pending of capture, where expected counts and values are worked out per case.

// File: rtl/gpt_pkg.sv
// Shared constants for the general-purpose timer: register offsets,
// control bit positions, status bit positions and output trigger codes.
package gpt_pkg;

    localparam int AW     = 8;
    localparam int CTRL_W = 15;
    localparam int NFLAG  = 3;

    localparam logic [AW-1:0] ADR_CTRL  = 8'h00;
    localparam logic [AW-1:0] ADR_COUNT = 8'h04;
    localparam logic [AW-1:0] ADR_LOAD  = 8'h08;
    localparam logic [AW-1:0] ADR_KICK  = 8'h0C;
    localparam logic [AW-1:0] ADR_MATCH = 8'h10;
    localparam logic [AW-1:0] ADR_CAPT  = 8'h14;
    localparam logic [AW-1:0] ADR_FLAGS = 8'h18;
    localparam logic [AW-1:0] ADR_IEN   = 8'h1C;

    localparam int B_START   = 0;
    localparam int B_AUTO    = 1;
    localparam int B_PS_LO   = 2;
    localparam int B_PS_HI   = 4;
    localparam int B_PS_EN   = 5;
    localparam int B_CMP_EN  = 6;
    localparam int B_IDLE    = 7;
    localparam int B_EDGE_LO = 8;
    localparam int B_EDGE_HI = 9;
    localparam int B_TRG_LO  = 10;
    localparam int B_TRG_HI  = 11;
    localparam int B_TOGGLE  = 12;
    localparam int B_HOLD    = 13;
    localparam int B_FORCE   = 14;

    localparam int F_MATCH = 0;
    localparam int F_WRAP  = 1;
    localparam int F_CAP   = 2;

    typedef enum logic [1:0] {
        TRG_NONE = 2'b00,
        TRG_WRAP = 2'b01,
        TRG_BOTH = 2'b10,
        TRG_RSVD = 2'b11
    } trig_e;

endpackage

// File: rtl/gpt_prescale.sv
// Prescaler: when enabled, emits a tick once every 2^(ratio+1) clocks
// while the timer runs; when disabled the tick is permanently high.
// Assumes ratio is stable while running; the phase restarts on stop.
module gpt_prescale #(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en,
    input  logic [RW-1:0] ratio,
    output logic          tick
);
    localparam int PCW = 1 << RW;

    logic [PCW-1:0] pcnt_q;
    logic [PCW:0]   span;
    logic [PCW-1:0] last;

    // Terminal phase value derived from the selected ratio.
    always_comb begin
        span = (PCW+1)'(1) << (32'(ratio) + 1);
        last = PCW'(span - 1'b1);
    end

    // Phase counter, cleared whenever the prescaler is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !en) begin
            pcnt_q <= '0;
        end else if (pcnt_q == last) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign tick = !en || (pcnt_q == last);
endmodule

// File: rtl/gpt_capture.sv
// Capture path: synchronises the external pin, detects the selected
// edges and latches the count. Assumes the pin is asynchronous.
module gpt_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [1:0]    edge_sel,
    input  logic          hold,
    input  logic          flag_pend,
    input  logic [DW-1:0] count,
    output logic          cap_evt,
    output logic [DW-1:0] cap_val
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall, hit;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Edge qualification against the selection and the hold rule.
    always_comb begin
        rise    = s2_q && !prev_q;
        fall    = !s2_q && prev_q;
        hit     = (edge_sel[0] && rise) || (edge_sel[1] && fall);
        cap_evt = hit && !(hold && flag_pend);
    end

    // Captured count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (cap_evt) begin
            cap_val <= count;
        end
    end
endmodule

// File: rtl/gpt_outgen.sv
// Output pin generator: idle level, one-cycle pulse or toggle per
// selected event, or forced idle level. Events arrive as strobes.
module gpt_outgen
    import gpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_lvl,
    input  logic       toggle,
    input  logic       force_idle,
    input  logic [1:0] trig,
    input  logic       wrap_evt,
    input  logic       match_evt,
    output logic       pin
);
    logic evt;
    logic pulse_q, tog_q;

    // Event selection from the trigger code.
    always_comb begin
        unique case (trig_e'(trig))
            TRG_WRAP: evt = wrap_evt;
            TRG_BOTH: evt = wrap_evt || match_evt;
            default:  evt = 1'b0;
        endcase
    end

    // Pulse and toggle state; toggle state is cleared outside toggle mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= evt;
            tog_q   <= toggle ? (tog_q ^ evt) : 1'b0;
        end
    end

    assign pin = force_idle ? idle_lvl : (idle_lvl ^ (toggle ? tog_q : pulse_q));
endmodule

// File: rtl/gpt_core.sv
// General-purpose timer top: register file, 32-bit up-counter with
// prescaler, reload/one-shot wrap, compare, capture and output pin.
// Assumes one register write per cycle and a single clock domain.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cap_pin,
    output logic          timer_out,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     cnt_q, load_q, match_q, cap_val;
    logic [NFLAG-1:0]  flags_q, ien_q, set_vec, clr_vec;
    logic              tick, step, at_top, wrap_evt, match_evt, cap_evt;
    logic [DW-1:0]     cnt_next;
    logic              wr_ctrl, wr_count, wr_load, wr_kick, wr_match, wr_flags, wr_ien;

    // Write decode.
    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);
        wr_count = reg_we && (reg_addr == ADR_COUNT);
        wr_load  = reg_we && (reg_addr == ADR_LOAD);
        wr_kick  = reg_we && (reg_addr == ADR_KICK);
        wr_match = reg_we && (reg_addr == ADR_MATCH);
        wr_flags = reg_we && (reg_addr == ADR_FLAGS);
        wr_ien   = reg_we && (reg_addr == ADR_IEN);
    end

    gpt_prescale #(.RW(RW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q[B_START]),
        .en    (ctrl_q[B_PS_EN]),
        .ratio (ctrl_q[B_PS_HI:B_PS_LO]),
        .tick  (tick)
    );

    // Next count, wrap and match events.
    always_comb begin
        step      = ctrl_q[B_START] && tick;
        at_top    = &cnt_q;
        wrap_evt  = step && at_top;
        cnt_next  = at_top ? (ctrl_q[B_AUTO] ? load_q : '0) : cnt_q + 1'b1;
        match_evt = step && ctrl_q[B_CMP_EN] && (cnt_next == match_q);
    end

    // Counter: software write, then reload strobe, then counting step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_count) begin
            cnt_q <= reg_wdata;
        end else if (wr_kick) begin
            cnt_q <= load_q;
        end else if (step) begin
            cnt_q <= cnt_next;
        end
    end

    // Control word; a one-shot wrap clears the start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata[CTRL_W-1:0];
        end else if (wrap_evt && !ctrl_q[B_AUTO]) begin
            ctrl_q[B_START] <= 1'b0;
        end
    end

    // Reload, match and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            match_q <= '0;
            ien_q   <= '0;
        end else begin
            if (wr_load)  load_q  <= reg_wdata;
            if (wr_match) match_q <= reg_wdata;
            if (wr_ien)   ien_q   <= reg_wdata[NFLAG-1:0];
        end
    end

    gpt_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (cap_pin),
        .edge_sel  (ctrl_q[B_EDGE_HI:B_EDGE_LO]),
        .hold      (ctrl_q[B_HOLD]),
        .flag_pend (flags_q[F_CAP]),
        .count     (cnt_q),
        .cap_evt   (cap_evt),
        .cap_val   (cap_val)
    );

    // Flag set and clear vectors.
    always_comb begin
        set_vec          = '0;
        set_vec[F_MATCH] = match_evt;
        set_vec[F_WRAP]  = wrap_evt;
        set_vec[F_CAP]   = cap_evt;
        clr_vec          = wr_flags ? reg_wdata[NFLAG-1:0] : '0;
    end

    // Sticky status flags, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
        end
    end

    gpt_outgen u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_lvl   (ctrl_q[B_IDLE]),
        .toggle     (ctrl_q[B_TOGGLE]),
        .force_idle (ctrl_q[B_FORCE]),
        .trig       (ctrl_q[B_TRG_HI:B_TRG_LO]),
        .wrap_evt   (wrap_evt),
        .match_evt  (match_evt),
        .pin        (timer_out)
    );

    // Read mux.
    always_comb begin
        unique case (reg_addr)
            ADR_CTRL:  reg_rdata = DW'(ctrl_q);
            ADR_COUNT: reg_rdata = cnt_q;
            ADR_LOAD:  reg_rdata = load_q;
            ADR_MATCH: reg_rdata = match_q;
            ADR_CAPT:  reg_rdata = cap_val;
            ADR_FLAGS: reg_rdata = DW'(flags_q);
            ADR_IEN:   reg_rdata = DW'(ien_q);
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(flags_q & ien_q);
endmodule

// File: rtl/gpt_core_chk.sv
// Checker for gpt_core: cycle-by-cycle properties of the counter,
// status flags, output pin and interrupt line. Bound to the top.
module gpt_core_chk
    import gpt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic             clr_wrap,
    input logic             st,
    input logic             ar,
    input logic             ps_en,
    input logic             idle_lvl,
    input logic             force_idle,
    input logic [DW-1:0]    cnt,
    input logic [DW-1:0]    load,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] ien,
    input logic             tick,
    input logic             wrap_evt,
    input logic             timer_out,
    input logic             irq
);
    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st && !reg_we) |=> $stable(cnt));

    p_run_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st && !ps_en && !reg_we && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st && ar && tick && (&cnt) && !reg_we) |=> ((cnt == $past(load)) && flags[F_WRAP]));

    p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st && !ar && tick && (&cnt) && !reg_we) |=> ((cnt == '0) && !st));

    p_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADR_KICK)) |=> (cnt == $past(load)));

    p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> (timer_out == idle_lvl));

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADR_FLAGS) && clr_wrap && !wrap_evt) |=> !flags[F_WRAP]);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ien) == '0) |-> !irq);
endmodule

bind gpt_core gpt_core_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .clr_wrap   (reg_wdata[gpt_pkg::F_WRAP]),
    .st         (ctrl_q[gpt_pkg::B_START]),
    .ar         (ctrl_q[gpt_pkg::B_AUTO]),
    .ps_en      (ctrl_q[gpt_pkg::B_PS_EN]),
    .idle_lvl   (ctrl_q[gpt_pkg::B_IDLE]),
    .force_idle (ctrl_q[gpt_pkg::B_FORCE]),
    .cnt        (cnt_q),
    .load       (load_q),
    .flags      (flags_q),
    .ien        (ien_q),
    .tick       (tick),
    .wrap_evt   (wrap_evt),
    .timer_out  (timer_out),
    .irq        (irq)
);

// File: tb/gpt_core_test.sv
// Self-checking bench for gpt_core: a prescaler vector table walked by
// one loop, then directed scenarios for each requirement.
module gpt_core_test;
    import gpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        pre;
        logic [2:0]  ratio;
        logic [31:0] cycles;
        logic [31:0] expect_cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 3'd0, 32'd10,  32'd10},
        '{1'b1, 3'd0, 32'd10,  32'd5},
        '{1'b1, 3'd1, 32'd17,  32'd4},
        '{1'b1, 3'd2, 32'd23,  32'd2},
        '{1'b1, 3'd3, 32'd48,  32'd3},
        '{1'b1, 3'd7, 32'd600, 32'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_pin = 1'b0;
    logic        timer_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    gpt_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_pin   (cap_pin),
        .timer_out (timer_out),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(ADR_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(ADR_COUNT, v); chk("R1 count", v, 0);
        rd(ADR_FLAGS, v); chk("R1 flags", v, 0);
        chk("R1 timer_out", {31'd0, timer_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2/R3 prescaler table
        for (int i = 0; i < 6; i++) begin
            wr(ADR_CTRL, 0);
            wr(ADR_COUNT, 0);
            wr(ADR_CTRL, (32'(VECS[i].pre) << B_PS_EN) | (32'(VECS[i].ratio) << B_PS_LO) | 32'h1);
            step(int'(VECS[i].cycles));
            rd(ADR_COUNT, v);
            chk(VECS[i].pre ? "R3 prescaled count" : "R2 plain count", v, VECS[i].expect_cnt);
        end

        // R2 stop holds the count
        wr(ADR_CTRL, 0);
        wr(ADR_COUNT, 32'h10);
        wr(ADR_CTRL, 1);
        step(4);
        wr(ADR_CTRL, 0);
        rd(ADR_COUNT, v);  chk("R2 last step", v, 32'h15);
        step(5);
        rd(ADR_COUNT, v2); chk("R2 hold", v2, 32'h15);

        // R4 auto-reload wrap, R11 irq, R10 clear
        wr(ADR_LOAD, 32'h100);
        wr(ADR_IEN, 32'h2);
        wr(ADR_COUNT, 32'hFFFF_FFFD);
        wr(ADR_CTRL, 32'h3);
        step(2);
        rd(ADR_COUNT, v); chk("R4 before wrap", v, 32'hFFFF_FFFF);
        chk("R11 irq low before wrap", {31'd0, irq}, 0);
        step(1);
        rd(ADR_COUNT, v); chk("R4 reloaded", v, 32'h100);
        rd(ADR_FLAGS, v); chk("R4 wrap flag", v & 32'h2, 32'h2);
        chk("R11 irq high", {31'd0, irq}, 1);
        wr(ADR_FLAGS, 32'h2);
        rd(ADR_FLAGS, v); chk("R10 cleared", v, 0);
        chk("R11 irq after clear", {31'd0, irq}, 0);
        wr(ADR_CTRL, 0);

        // R5 one-shot wrap stops the timer
        wr(ADR_COUNT, 32'hFFFF_FFFE);
        wr(ADR_CTRL, 1);
        step(2);
        rd(ADR_COUNT, v); chk("R5 wrapped to zero", v, 0);
        rd(ADR_CTRL, v);  chk("R5 start cleared", v, 0);
        step(3);
        rd(ADR_COUNT, v); chk("R5 stays stopped", v, 0);
        wr(ADR_FLAGS, 32'h1);
        rd(ADR_FLAGS, v); chk("R10 zero bit leaves wrap flag", v, 32'h2);
        wr(ADR_IEN, 0);
        chk("R11 masked flag", {31'd0, irq}, 0);
        wr(ADR_FLAGS, 32'h7);

        // R6 reload strobe
        wr(ADR_LOAD, 32'h55);
        wr(ADR_KICK, 32'hDEAD);
        rd(ADR_COUNT, v); chk("R6 strobe load", v, 32'h55);

        // R7 compare enabled and disabled
        wr(ADR_COUNT, 0);
        wr(ADR_MATCH, 5);
        wr(ADR_CTRL, 32'h41);
        step(4);
        rd(ADR_FLAGS, v); chk("R7 no match yet", v & 1, 0);
        step(1);
        rd(ADR_FLAGS, v); chk("R7 match flag", v & 1, 1);
        wr(ADR_CTRL, 0);
        wr(ADR_FLAGS, 32'h7);
        wr(ADR_COUNT, 0);
        wr(ADR_MATCH, 3);
        wr(ADR_CTRL, 1);
        step(6);
        rd(ADR_FLAGS, v); chk("R7 compare disabled", v & 1, 0);
        wr(ADR_CTRL, 0);

        // R9 pulse on match
        wr(ADR_COUNT, 0);
        wr(ADR_CTRL, 32'h841);
        step(2); chk("R9 pulse idle", {31'd0, timer_out}, 0);
        step(1); chk("R9 pulse active", {31'd0, timer_out}, 1);
        step(1); chk("R9 pulse ends", {31'd0, timer_out}, 0);
        wr(ADR_CTRL, 0);
        // R9 trigger code 00 produces nothing
        wr(ADR_COUNT, 0);
        wr(ADR_CTRL, 32'h1041);
        step(5); chk("R9 no trigger", {31'd0, timer_out}, 0);
        wr(ADR_CTRL, 0);
        // R9 toggle on match
        wr(ADR_COUNT, 0);
        wr(ADR_CTRL, 32'h1841);
        step(2); chk("R9 toggle before", {31'd0, timer_out}, 0);
        step(1); chk("R9 toggled", {31'd0, timer_out}, 1);
        step(3); chk("R9 toggle holds", {31'd0, timer_out}, 1);
        wr(ADR_CTRL, 0);
        step(1);
        // R9 idle level and forced level
        wr(ADR_CTRL, 32'h80);
        chk("R9 idle high", {31'd0, timer_out}, 1);
        wr(ADR_CTRL, 32'h4000);
        chk("R9 forced low", {31'd0, timer_out}, 0);
        wr(ADR_CTRL, 32'h4080);
        chk("R9 forced high", {31'd0, timer_out}, 1);
        // R9 pulse on wrap with idle high
        wr(ADR_COUNT, 32'hFFFF_FFFE);
        wr(ADR_CTRL, 32'h483);
        step(1); chk("R9 wrap pulse idle", {31'd0, timer_out}, 1);
        step(1); chk("R9 wrap pulse", {31'd0, timer_out}, 0);
        wr(ADR_CTRL, 0);
        wr(ADR_FLAGS, 32'h7);

        // R8 capture edges
        wr(ADR_COUNT, 32'h1234);
        wr(ADR_CTRL, 32'h100);
        cap_pin = 1'b1; step(3);
        rd(ADR_CAPT, v);  chk("R8 rising capture", v, 32'h1234);
        rd(ADR_FLAGS, v); chk("R8 capture flag", v & 4, 4);
        wr(ADR_FLAGS, 32'h7);
        cap_pin = 1'b0; step(3);
        rd(ADR_FLAGS, v); chk("R8 falling ignored in rising mode", v & 4, 0);
        wr(ADR_CTRL, 32'h200);
        wr(ADR_COUNT, 32'h2222);
        cap_pin = 1'b1; step(3);
        rd(ADR_CAPT, v); chk("R8 rising ignored in falling mode", v, 32'h1234);
        cap_pin = 1'b0; step(3);
        rd(ADR_CAPT, v); chk("R8 falling capture", v, 32'h2222);
        wr(ADR_FLAGS, 32'h7);
        wr(ADR_CTRL, 32'h300);
        wr(ADR_COUNT, 32'h3333);
        cap_pin = 1'b1; step(3);
        rd(ADR_CAPT, v); chk("R8 both edges", v, 32'h3333);
        wr(ADR_CTRL, 32'h2300);
        wr(ADR_COUNT, 32'h4444);
        cap_pin = 1'b0; step(3);
        rd(ADR_CAPT, v); chk("R8 hold while pending", v, 32'h3333);
        wr(ADR_FLAGS, 32'h4);
        cap_pin = 1'b1; step(3);
        rd(ADR_CAPT, v); chk("R8 capture after clear", v, 32'h4444);
        wr(ADR_CTRL, 0);
        wr(ADR_COUNT, 32'h5555);
        cap_pin = 1'b0; step(3);
        rd(ADR_CAPT, v); chk("R8 no edge selected", v, 32'h4444);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule